// File: doc/BRIEF.md
# Router IO Controller Register File with Network Interrupt Aggregation

This block is a small memory-mapped register file for a router-class IO controller. A host CPU reaches it through a byte-offset address, read and write strobes and a 32-bit data path. Reads are combinational: `bus_rdata` follows the addressed register while `bus_rd` is high. Writes take effect at the next rising clock edge.

Network interfaces sit in two slots. Each one raises and lowers its interrupt with single-cycle set and clear pulses. The block gathers these pulses into one status register and drives a single combined interrupt line. Each bit position is a per-slot base plus the port number: slot 1 starts at bit 0 and slot 0 starts at bit 4.

The register file also holds several other registers:
- a writable card-select byte;
- a presence register that merges a fixed pattern with live card-detect inputs;
- two pin-latch registers that let software bit-bang serial EEPROMs, one on the main board and one on an expansion card;
- two offsets that always read zero.

Top module: `iorf_top`

## Requirements
- R1: A read at offset 0x08 returns the interrupt status in bits 5:0. Port p of slot 1 (p = 0..3) owns bit p, port p of slot 0 (p = 0..1) owns bit 4+p, and bits 31:6 read zero.
- R2: A set pulse on a port sets its status bit at the next clock edge, and a clear pulse clears it. When both arrive for the same bit in the same cycle, the bit ends up set. With no pulse, a bit holds its value.
- R3: `net_irq` is high exactly when the status register held at least one set bit at the previous clock edge, so it lags the register by one cycle.
- R4: Offset 0x10 is a read-write 8-bit card-select register. A read returns the last byte written in bits 7:0, and the register drives `card_sel`.
- R5: A read at offset 0x0C returns 0x10, with bit 1 set while `card_present[0]` is high and bit 2 set while `card_present[1]` is high.
- R6: Reads at offsets 0x04 and 0x14 return zero, and writes there change nothing.
- R7: A write at offset 0x1C drives the expansion EEPROM pins as follows: chip select from bit 4, clock from bit 2 and data-in from bit 6. A read there returns `exp_ee_do` in bit 7 and zero elsewhere.
- R8: A write at offset 0x18 drives the main-board EEPROM pins as follows: chip select from bit 0, clock from bit 1 and data-in from bit 2. A read there returns `mb_ee_do` in bit 3 and zero elsewhere.
- R9: Any offset that is not listed reads zero. Writes to unlisted offsets, to 0x08 and to 0x0C alter no register.
- R10: While `rst` is high, and after it is released, all registers, pins and `net_irq` are zero.
- R11: `bus_rdata` is zero whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| s0_irq_set | input | 2 | Slot 0 per-port interrupt set pulses |
| s0_irq_clr | input | 2 | Slot 0 per-port interrupt clear pulses |
| s1_irq_set | input | 4 | Slot 1 per-port interrupt set pulses |
| s1_irq_clr | input | 4 | Slot 1 per-port interrupt clear pulses |
| net_irq | output | 1 | Combined network interrupt |
| card_present | input | 2 | Card-detect inputs |
| card_sel | output | 8 | Card-select register value |
| mb_ee_cs | output | 1 | Main-board EEPROM chip select |
| mb_ee_sk | output | 1 | Main-board EEPROM clock |
| mb_ee_di | output | 1 | Main-board EEPROM data to device |
| mb_ee_do | input | 1 | Main-board EEPROM data from device |
| exp_ee_cs | output | 1 | Expansion EEPROM chip select |
| exp_ee_sk | output | 1 | Expansion EEPROM clock |
| exp_ee_di | output | 1 | Expansion EEPROM data to device |
| exp_ee_do | input | 1 | Expansion EEPROM data from device |

## Verification
The bench builds the block with its default parameters: two ports in slot 0 based at bit 4, four ports in slot 1 based at bit 0, and a six-bit status register. With these values every status bit is reachable from exactly one port, including the slot-0 bits that sit above the slot-1 range. Same-cycle set and clear collisions can therefore be driven on every bit. The EEPROM pin latches use their distinct bit placements, so a swapped chip-select, clock or data field changes a visible pin.

// File: rtl/iorf_pkg.sv
package iorf_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFS_ZERO_A = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_NETIRQ = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_PRES   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_CSEL   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_ZERO_B = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_MB_EE  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_EXP_EE = 8'h1C;

    // Presence register fixed pattern and first live bit
    localparam logic [DATA_W-1:0] PRES_BASE = 32'h0000_0010;
    localparam int                PRES_LSB  = 1;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } ee_pins_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ZERO,
        SEL_NETIRQ,
        SEL_PRES,
        SEL_CSEL,
        SEL_MB_EE,
        SEL_EXP_EE
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_ZERO_A, OFS_ZERO_B: s = SEL_ZERO;
            OFS_NETIRQ:             s = SEL_NETIRQ;
            OFS_PRES:               s = SEL_PRES;
            OFS_CSEL:               s = SEL_CSEL;
            OFS_MB_EE:              s = SEL_MB_EE;
            OFS_EXP_EE:             s = SEL_EXP_EE;
            default:                s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Status bit owned by a port: slot base plus port number
    function automatic int irq_pos(input int base, input int port);
        return base + port;
    endfunction

endpackage

// File: rtl/iorf_irq_agg.sv
module iorf_irq_agg
    import iorf_pkg::*;
#(
    parameter int S0_PORTS = 2,
    parameter int S1_PORTS = 4,
    parameter int S0_BASE  = 4,
    parameter int S1_BASE  = 0,
    parameter int STAT_W   = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [S0_PORTS-1:0] s0_set,
    input  logic [S0_PORTS-1:0] s0_clr,
    input  logic [S1_PORTS-1:0] s1_set,
    input  logic [S1_PORTS-1:0] s1_clr,
    output logic [STAT_W-1:0]   status,
    output logic                irq_o
);

    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] status_nx;

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        for (int p = 0; p < S0_PORTS; p++) begin
            set_vec[irq_pos(S0_BASE, p)] = s0_set[p];
            clr_vec[irq_pos(S0_BASE, p)] = s0_clr[p];
        end
        for (int p = 0; p < S1_PORTS; p++) begin
            set_vec[irq_pos(S1_BASE, p)] = s1_set[p];
            clr_vec[irq_pos(S1_BASE, p)] = s1_clr[p];
        end
        // set applied after clear so that a collision leaves the bit set
        status_nx = (status & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            irq_o  <= 1'b0;
        end else begin
            status <= status_nx;
            irq_o  <= |status;
        end
    end

    // R2
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

    // R2
    clear_only_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr_vec & ~set_vec)) |=> ((status & $past(clr_vec & ~set_vec)) == '0));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (set_vec == '0 && clr_vec == '0) |=> $stable(status));

    // R3
    irq_lag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == ($past(status) != '0)));

endmodule

// File: rtl/iorf_ee_port.sv
module iorf_ee_port
    import iorf_pkg::*;
#(
    parameter int CS_BIT = 4,
    parameter int SK_BIT = 2,
    parameter int DI_BIT = 6,
    parameter int DO_BIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ee_do,
    output ee_pins_t          pins,
    output logic [DATA_W-1:0] rd_val
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pins <= '0;
        end else if (wr_en) begin
            pins.cs <= wdata[CS_BIT];
            pins.sk <= wdata[SK_BIT];
            pins.di <= wdata[DI_BIT];
        end
    end

    always_comb begin
        rd_val         = '0;
        rd_val[DO_BIT] = ee_do;
    end

    // R7 R8
    pin_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (pins.cs == $past(wdata[CS_BIT]) && pins.sk == $past(wdata[SK_BIT])
                   && pins.di == $past(wdata[DI_BIT])));

    // R9
    pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(pins));

endmodule

// File: rtl/iorf_top.sv
module iorf_top
    import iorf_pkg::*;
#(
    parameter int S0_PORTS = 2,
    parameter int S1_PORTS = 4,
    parameter int S0_BASE  = 4,
    parameter int S1_BASE  = 0,
    parameter int STAT_W   = 6,
    parameter int CSEL_W   = 8,
    parameter int NCARD    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [S0_PORTS-1:0] s0_irq_set,
    input  logic [S0_PORTS-1:0] s0_irq_clr,
    input  logic [S1_PORTS-1:0] s1_irq_set,
    input  logic [S1_PORTS-1:0] s1_irq_clr,
    output logic                net_irq,
    input  logic [NCARD-1:0]    card_present,
    output logic [CSEL_W-1:0]   card_sel,
    output logic                mb_ee_cs,
    output logic                mb_ee_sk,
    output logic                mb_ee_di,
    input  logic                mb_ee_do,
    output logic                exp_ee_cs,
    output logic                exp_ee_sk,
    output logic                exp_ee_di,
    input  logic                exp_ee_do
);

    reg_sel_e          sel;
    logic              wr_csel;
    logic              wr_mb;
    logic              wr_exp;
    logic [STAT_W-1:0] status;
    logic [DATA_W-1:0] pres_val;
    logic [DATA_W-1:0] mb_rd;
    logic [DATA_W-1:0] exp_rd;
    ee_pins_t          mb_pins;
    ee_pins_t          exp_pins;

    assign sel     = decode_ofs(bus_addr);
    assign wr_csel = bus_wr && (sel == SEL_CSEL);
    assign wr_mb   = bus_wr && (sel == SEL_MB_EE);
    assign wr_exp  = bus_wr && (sel == SEL_EXP_EE);

    iorf_irq_agg #(
        .S0_PORTS(S0_PORTS), .S1_PORTS(S1_PORTS),
        .S0_BASE(S0_BASE),   .S1_BASE(S1_BASE),
        .STAT_W(STAT_W)
    ) u_irq (
        .clk(clk), .rst(rst),
        .s0_set(s0_irq_set), .s0_clr(s0_irq_clr),
        .s1_set(s1_irq_set), .s1_clr(s1_irq_clr),
        .status(status), .irq_o(net_irq)
    );

    iorf_ee_port #(.CS_BIT(0), .SK_BIT(1), .DI_BIT(2), .DO_BIT(3)) u_mb_ee (
        .clk(clk), .rst(rst), .wr_en(wr_mb), .wdata(bus_wdata),
        .ee_do(mb_ee_do), .pins(mb_pins), .rd_val(mb_rd)
    );

    iorf_ee_port #(.CS_BIT(4), .SK_BIT(2), .DI_BIT(6), .DO_BIT(7)) u_exp_ee (
        .clk(clk), .rst(rst), .wr_en(wr_exp), .wdata(bus_wdata),
        .ee_do(exp_ee_do), .pins(exp_pins), .rd_val(exp_rd)
    );

    assign mb_ee_cs  = mb_pins.cs;
    assign mb_ee_sk  = mb_pins.sk;
    assign mb_ee_di  = mb_pins.di;
    assign exp_ee_cs = exp_pins.cs;
    assign exp_ee_sk = exp_pins.sk;
    assign exp_ee_di = exp_pins.di;

    always_ff @(posedge clk) begin
        if (rst)          card_sel <= '0;
        else if (wr_csel) card_sel <= bus_wdata[CSEL_W-1:0];
    end

    always_comb begin
        pres_val = PRES_BASE;
        for (int c = 0; c < NCARD; c++) begin
            pres_val[PRES_LSB + c] = card_present[c];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_NETIRQ: bus_rdata[STAT_W-1:0] = status;
                SEL_PRES:   bus_rdata = pres_val;
                SEL_CSEL:   bus_rdata[CSEL_W-1:0] = card_sel;
                SEL_MB_EE:  bus_rdata = mb_rd;
                SEL_EXP_EE: bus_rdata = exp_rd;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R4
    csel_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_csel |=> (card_sel == $past(bus_wdata[CSEL_W-1:0])));

    // R9
    csel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_csel |=> $stable(card_sel));

    // R11
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));

endmodule

// File: tb/iorf_top_tb.sv
`timescale 1ns/1ps
module iorf_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_wr, bus_rd;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [1:0]  s0_irq_set, s0_irq_clr;
    logic [3:0]  s1_irq_set, s1_irq_clr;
    logic        net_irq;
    logic [1:0]  card_present;
    logic [7:0]  card_sel;
    logic        mb_ee_cs, mb_ee_sk, mb_ee_di, mb_ee_do;
    logic        exp_ee_cs, exp_ee_sk, exp_ee_di, exp_ee_do;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    iorf_top u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .s0_irq_set(s0_irq_set), .s0_irq_clr(s0_irq_clr),
        .s1_irq_set(s1_irq_set), .s1_irq_clr(s1_irq_clr),
        .net_irq(net_irq), .card_present(card_present), .card_sel(card_sel),
        .mb_ee_cs(mb_ee_cs), .mb_ee_sk(mb_ee_sk), .mb_ee_di(mb_ee_di), .mb_ee_do(mb_ee_do),
        .exp_ee_cs(exp_ee_cs), .exp_ee_sk(exp_ee_sk), .exp_ee_di(exp_ee_di), .exp_ee_do(exp_ee_do)
    );

    // Behavioural reference model
    bit [5:0] m_stat;
    bit       m_irq;
    bit [7:0] m_csel;
    bit [2:0] m_exp;   // {cs, sk, di}
    bit [2:0] m_mb;    // {cs, sk, di}

    always @(posedge clk) begin
        if (rst) begin
            m_stat = 0; m_irq = 0; m_csel = 0; m_exp = 0; m_mb = 0;
        end else begin
            m_irq = (m_stat != 0);
            for (int p = 0; p < 2; p++) if (s0_irq_clr[p]) m_stat[4 + p] = 1'b0;
            for (int p = 0; p < 4; p++) if (s1_irq_clr[p]) m_stat[p] = 1'b0;
            for (int p = 0; p < 2; p++) if (s0_irq_set[p]) m_stat[4 + p] = 1'b1;
            for (int p = 0; p < 4; p++) if (s1_irq_set[p]) m_stat[p] = 1'b1;
            if (bus_wr) begin
                if (bus_addr == 8'h10) m_csel = bus_wdata[7:0];
                if (bus_addr == 8'h1C) m_exp = {bus_wdata[4], bus_wdata[2], bus_wdata[6]};
                if (bus_addr == 8'h18) m_mb = {bus_wdata[0], bus_wdata[1], bus_wdata[2]};
            end
        end
    end

    function automatic logic [31:0] exp_rdata();
        logic [31:0] v = 0;
        if (!bus_rd) return 0;
        case (bus_addr)
            8'h08: v = {26'd0, m_stat};
            8'h0C: v = 32'h10 | (32'(card_present[0]) << 1) | (32'(card_present[1]) << 2);
            8'h10: v = {24'd0, m_csel};
            8'h18: v = 32'(mb_ee_do) << 3;
            8'h1C: v = 32'(exp_ee_do) << 7;
            default: v = 0;
        endcase
        return v;
    endfunction

    function automatic string tag_of(logic [7:0] a);
        if (!bus_rd) return "R11";
        case (a)
            8'h08: return "R1 R2";
            8'h0C: return "R5";
            8'h10: return "R4";
            8'h04, 8'h14: return "R6";
            8'h18: return "R8";
            8'h1C: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string t;
        t = rst ? "R10" : tag_of(bus_addr);
        check(t, bus_rdata, exp_rdata());
        check(rst ? "R10" : "R3", {31'd0, net_irq}, {31'd0, m_irq});
        check(rst ? "R10" : "R4", {24'd0, card_sel}, {24'd0, m_csel});
        check(rst ? "R10" : "R7", {29'd0, exp_ee_cs, exp_ee_sk, exp_ee_di}, {29'd0, m_exp});
        check(rst ? "R10" : "R8", {29'd0, mb_ee_cs, mb_ee_sk, mb_ee_di}, {29'd0, m_mb});
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        s0_irq_set = 0; s0_irq_clr = 0; s1_irq_set = 0; s1_irq_clr = 0;
    endtask

    // One cycle: drive after the falling edge, compare shortly after
    task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                        input logic [31:0] d, input logic [1:0] s0s, input logic [1:0] s0c,
                        input logic [3:0] s1s, input logic [3:0] s1c);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        s0_irq_set = s0s; s0_irq_clr = s0c; s1_irq_set = s1s; s1_irq_clr = s1c;
        #1;
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [7:0] addrs [12];
        addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
                  8'h20, 8'h09, 8'h3C, 8'hFC};
        rst = 1; idle(); card_present = 0; mb_ee_do = 0; exp_ee_do = 0;
        // R10: reset state, with stimulus that must be overridden
        step(1, 1, 8'h10, 32'hFF, 2'b11, 2'b00, 4'hF, 4'h0);
        step(1, 1, 8'h1C, 32'hFF, 2'b00, 2'b00, 4'h0, 4'h0);
        step(0, 1, 8'h08, 0, 0, 0, 0, 0);
        @(negedge clk); rst = 0; idle(); #1; compare_all();
        step(0, 1, 8'h08, 0, 0, 0, 0, 0);

        // R1: each slot-1 port and each slot-0 port lands on its own bit
        for (int p = 0; p < 4; p++) begin
            step(0, 1, 8'h08, 0, 0, 0, 4'(1 << p), 0);
            step(0, 1, 8'h08, 0, 0, 0, 0, 4'(1 << p));
            step(0, 1, 8'h08, 0, 0, 0, 0, 0);
        end
        for (int p = 0; p < 2; p++) begin
            step(0, 1, 8'h08, 0, 2'(1 << p), 0, 0, 0);
            step(0, 1, 8'h08, 0, 0, 2'(1 << p), 0, 0);
            step(0, 1, 8'h08, 0, 0, 0, 0, 0);
        end
        // R2: same-cycle set and clear leaves the bit set
        step(0, 1, 8'h08, 0, 2'b10, 2'b10, 4'b0100, 4'b0100);
        step(0, 1, 8'h08, 0, 0, 0, 0, 0);
        // R3: combined line follows one cycle behind, then drops
        step(0, 1, 8'h08, 0, 0, 2'b11, 0, 4'hF);
        step(0, 1, 8'h08, 0, 0, 0, 0, 0);
        step(0, 1, 8'h08, 0, 0, 0, 0, 0);
        // R4 / R9: card-select write, then ignored writes elsewhere
        step(1, 1, 8'h10, 32'hDEAD_BEA5, 0, 0, 0, 0);
        step(1, 1, 8'h08, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step(1, 1, 8'h0C, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step(1, 1, 8'h24, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step(0, 1, 8'h10, 0, 0, 0, 0, 0);
        step(0, 1, 8'h08, 0, 0, 0, 0, 0);
        // R6: zero offsets
        step(1, 1, 8'h04, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step(1, 1, 8'h14, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step(0, 1, 8'h10, 0, 0, 0, 0, 0);
        // R5: presence patterns
        for (int c = 0; c < 4; c++) begin
            card_present = 2'(c);
            step(0, 1, 8'h0C, 0, 0, 0, 0, 0);
        end
        // R7 / R8: single pin bits through both latches
        for (int b = 0; b < 8; b++) begin
            step(1, 0, 8'h1C, 32'(1 << b), 0, 0, 0, 0);
            step(1, 0, 8'h18, 32'(1 << b), 0, 0, 0, 0);
        end
        exp_ee_do = 1; step(0, 1, 8'h1C, 0, 0, 0, 0, 0);
        mb_ee_do = 1;  step(0, 1, 8'h18, 0, 0, 0, 0, 0);

        // Mixed random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] sel;
            sel = 4'($urandom_range(0, 11));
            card_present = 2'($urandom);
            mb_ee_do = 1'($urandom);
            exp_ee_do = 1'($urandom);
            step(($urandom % 3) == 0, ($urandom % 5) != 0, addrs[sel], $urandom,
                 2'($urandom & $urandom), 2'($urandom & $urandom),
                 4'($urandom & $urandom), 4'($urandom & $urandom));
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule